// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns 32-bit linear addresses into physical addresses. With translation switched on, it looks up a four-entry translation cache first. On a miss it reads a directory entry and then a page-table entry from external memory, one read after the other. It combines the permission bits of both levels, answers with a physical address or a fault, and caches the result. With translation switched off, every address passes through unchanged.

Privileged software loads the directory root and the translation-enable bit together with one write strobe. That same write empties the translation cache. Requests come one at a time. The block takes a new one only while it is idle and no configuration write is pending. Each answer is a single-cycle response pulse.

Top module: `xlate_walker`

## Requirements
- R1: After reset, translation is disabled and the translation cache is empty. `req_ready` is high, and `rsp_valid` and `mem_rd_valid` are low.
- R2: While translation is disabled, an accepted request gets its response in the cycle after acceptance. `rsp_paddr` equals `req_addr`, there is no fault and no memory read.
- R3: On a cache miss, the directory entry is read at `{root_pfn, la[31:22], 2'b00}` in the cycle after acceptance. The table entry is read at `{dir_frame, la[21:12], 2'b00}` in the cycle after the directory data returns. The response comes in the cycle after the table data returns, with `rsp_paddr = {table_frame, la[11:0]}`.
- R4: An entry's bit 0 is present, bit 1 is writable, bit 2 is user and bits [31:12] are the frame. Bits [11:3] are ignored. A clear present bit at either level gives a not-present fault. A non-present directory entry ends the walk after one read. A walk that ends in a not-present fault leaves nothing in the cache.
- R5: A write faults with a protection cause when the writable bit is clear at either level. This holds for walked and cached translations alike.
- R6: A user access faults with a protection cause when the user bit is clear at either level. This holds for walked and cached translations alike.
- R7: `rsp_cause` bit 0 is 1 for protection and 0 for not-present. Bit 1 is the request's write flag and bit 2 its user flag. On a fault, `rsp_paddr` holds the linear address. Without a fault, `rsp_cause` is 0.
- R8: A cache hit answers in the cycle after acceptance with no memory read. It uses the cached frame and the cached combined permissions.
- R9: Every walk that reaches a present table entry fills a cache slot. Slots are filled in the order 0, 1, 2, 3, 0, … starting from slot 0 after reset or after any configuration write. The fifth distinct page therefore evicts the first.
- R10: A configuration write loads the root frame and the enable bit and empties the cache. The next access to a page cached before the write walks memory again.
- R11: From the acceptance of a miss until its response, `req_ready` is low. Each memory read request is a one-cycle `mem_rd_valid` pulse, and only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_addr | input | 32 | Linear address |
| req_write | input | 1 | Request is a write |
| req_user | input | 1 | Request comes from user mode |
| req_ready | output | 1 | Block can accept a request this cycle |
| cfg_wr | input | 1 | Privileged write of root and enable; flushes cache |
| cfg_root_pfn | input | 20 | Frame number of the page directory |
| cfg_paging | input | 1 | Translation enable value to load |
| mem_rd_valid | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | 32 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is valid this cycle |
| mem_rsp_data | input | 32 | Entry returned by memory |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Physical address, or linear address on fault |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_cause | output | 3 | Fault cause: {user, write, protection} |

## Verification
Pass-through responses and cache hits are due exactly one cycle after the accepting edge. With a memory latency of L cycles, a full walk answers 2L+3 cycles after acceptance and a walk stopped by a non-present directory entry answers after L+2. The bench samples on falling edges and counts cycles from the accepting edge to the first `rsp_valid`. It also counts memory reads and logs their addresses. It runs walks at two latencies, so each latency rule is checked as an exact cycle number rather than a wait-until.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    localparam int LA_W  = 32;
    localparam int OFS_W = 12;
    localparam int IDX_W = 10;
    localparam int PN_W  = LA_W - OFS_W;

    // Memory-resident entry layout (both levels)
    typedef struct packed {
        logic [PN_W-1:0]  frame;
        logic [OFS_W-4:0] spare;
        logic             usr;
        logic             wrt;
        logic             pres;
    } pte_t;

    // One cached translation with combined permissions
    typedef struct packed {
        logic [PN_W-1:0] vpn;
        logic [PN_W-1:0] pfn;
        logic            wrt;
        logic            usr;
    } tlb_ent_t;

    typedef struct packed {
        logic usr;
        logic wrt;
        logic prot;
    } fcause_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_WT,
        ST_TBL_RD,
        ST_TBL_WT
    } walk_st_e;

    function automatic logic access_ok(input logic wrt_ok, input logic usr_ok,
                                       input logic is_wr,  input logic is_usr);
        return !(is_wr && !wrt_ok) && !(is_usr && !usr_ok);
    endfunction

    function automatic logic [IDX_W-1:0] dir_idx(input logic [LA_W-1:0] la);
        return la[LA_W-1 -: IDX_W];
    endfunction

    function automatic logic [IDX_W-1:0] tbl_idx(input logic [LA_W-1:0] la);
        return la[OFS_W +: IDX_W];
    endfunction

    function automatic logic [LA_W-1:0] entry_addr(input logic [PN_W-1:0] base,
                                                   input logic [IDX_W-1:0] idx);
        return {base, idx, 2'b00};
    endfunction

    function automatic fcause_t mk_cause(input logic prot, input logic wrt, input logic usr);
        fcause_t c;
        c.prot = prot;
        c.wrt  = wrt;
        c.usr  = usr;
        return c;
    endfunction

endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb
    import xlate_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic [PN_W-1:0] lk_vpn,
    output logic            lk_hit,
    output logic [PN_W-1:0] lk_pfn,
    output logic            lk_wrt,
    output logic            lk_usr,
    input  logic            fill_en,
    input  tlb_ent_t        fill_ent
);

    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    tlb_ent_t           ent_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] match;
    logic [PTR_W-1:0]   ptr_q;

    genvar gi;
    generate
        for (gi = 0; gi < ENTRIES; gi++) begin : g_slot
            assign match[gi] = vld_q[gi] && (ent_q[gi].vpn == lk_vpn);
        end
    endgenerate

    assign lk_hit = |match;

    always_comb begin
        lk_pfn = '0;
        lk_wrt = 1'b0;
        lk_usr = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_pfn = lk_pfn | ent_q[i].pfn;
                lk_wrt = lk_wrt | ent_q[i].wrt;
                lk_usr = lk_usr | ent_q[i].usr;
            end
        end
    end

    // Valid bits and round-robin victim pointer; flush restarts at slot 0
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else if (fill_en) begin
            vld_q[ptr_q] <= 1'b1;
            ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            ent_q[ptr_q] <= fill_ent;
        end
    end

endmodule

// File: rtl/xlate_walk.sv
module xlate_walk
    import xlate_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [LA_W-1:0] req_addr,
    input  logic            req_write,
    input  logic            req_user,
    output logic            req_ready,
    input  logic            cfg_busy,
    input  logic            pg_en,
    input  logic [PN_W-1:0] root_pfn,
    input  logic            tlb_hit,
    input  logic [PN_W-1:0] tlb_pfn,
    input  logic            tlb_wrt,
    input  logic            tlb_usr,
    output logic            fill_en,
    output tlb_ent_t        fill_ent,
    output logic            mem_rd_valid,
    output logic [LA_W-1:0] mem_rd_addr,
    input  logic            mem_rsp_valid,
    input  logic [LA_W-1:0] mem_rsp_data,
    output logic            rsp_valid,
    output logic [LA_W-1:0] rsp_paddr,
    output logic            rsp_fault,
    output fcause_t         rsp_cause
);

    walk_st_e        st_q;
    logic [LA_W-1:0] la_q;
    logic            wr_q;
    logic            usr_q;
    logic [PN_W-1:0] root_q;
    logic [PN_W-1:0] dir_frame_q;
    logic            dir_wrt_q;
    logic            dir_usr_q;

    pte_t fetched;
    logic spare_unused;
    assign fetched      = pte_t'(mem_rsp_data);
    assign spare_unused = ^fetched.spare;

    logic accept;
    logic hit_ok;
    logic comb_wrt;
    logic comb_usr;
    logic leaf_ok;
    logic leaf_done;

    assign req_ready = (st_q == ST_IDLE) && !cfg_busy;
    assign accept    = req_valid && req_ready;
    assign hit_ok    = access_ok(tlb_wrt, tlb_usr, req_write, req_user);
    assign comb_wrt  = dir_wrt_q && fetched.wrt;
    assign comb_usr  = dir_usr_q && fetched.usr;
    assign leaf_ok   = access_ok(comb_wrt, comb_usr, wr_q, usr_q);
    assign leaf_done = (st_q == ST_TBL_WT) && mem_rsp_valid;

    // Cache fill on every walk that reaches a present leaf
    assign fill_en      = leaf_done && fetched.pres;
    assign fill_ent.vpn = la_q[LA_W-1:OFS_W];
    assign fill_ent.pfn = fetched.frame;
    assign fill_ent.wrt = comb_wrt;
    assign fill_ent.usr = comb_usr;

    always_comb begin
        mem_rd_valid = 1'b0;
        mem_rd_addr  = '0;
        case (st_q)
            ST_DIR_RD: begin
                mem_rd_valid = 1'b1;
                mem_rd_addr  = entry_addr(root_q, dir_idx(la_q));
            end
            ST_TBL_RD: begin
                mem_rd_valid = 1'b1;
                mem_rd_addr  = entry_addr(dir_frame_q, tbl_idx(la_q));
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            la_q        <= '0;
            wr_q        <= 1'b0;
            usr_q       <= 1'b0;
            root_q      <= '0;
            dir_frame_q <= '0;
            dir_wrt_q   <= 1'b0;
            dir_usr_q   <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_paddr   <= '0;
            rsp_fault   <= 1'b0;
            rsp_cause   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        la_q   <= req_addr;
                        wr_q   <= req_write;
                        usr_q  <= req_user;
                        root_q <= root_pfn;
                        if (!pg_en) begin
                            rsp_valid <= 1'b1;
                            rsp_paddr <= req_addr;
                            rsp_fault <= 1'b0;
                            rsp_cause <= '0;
                        end else if (tlb_hit) begin
                            rsp_valid <= 1'b1;
                            if (hit_ok) begin
                                rsp_paddr <= {tlb_pfn, req_addr[OFS_W-1:0]};
                                rsp_fault <= 1'b0;
                                rsp_cause <= '0;
                            end else begin
                                rsp_paddr <= req_addr;
                                rsp_fault <= 1'b1;
                                rsp_cause <= mk_cause(1'b1, req_write, req_user);
                            end
                        end else begin
                            st_q <= ST_DIR_RD;
                        end
                    end
                end
                ST_DIR_RD: st_q <= ST_DIR_WT;
                ST_DIR_WT: begin
                    if (mem_rsp_valid) begin
                        if (!fetched.pres) begin
                            st_q      <= ST_IDLE;
                            rsp_valid <= 1'b1;
                            rsp_paddr <= la_q;
                            rsp_fault <= 1'b1;
                            rsp_cause <= mk_cause(1'b0, wr_q, usr_q);
                        end else begin
                            st_q        <= ST_TBL_RD;
                            dir_frame_q <= fetched.frame;
                            dir_wrt_q   <= fetched.wrt;
                            dir_usr_q   <= fetched.usr;
                        end
                    end
                end
                ST_TBL_RD: st_q <= ST_TBL_WT;
                ST_TBL_WT: begin
                    if (mem_rsp_valid) begin
                        st_q      <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        if (!fetched.pres) begin
                            rsp_paddr <= la_q;
                            rsp_fault <= 1'b1;
                            rsp_cause <= mk_cause(1'b0, wr_q, usr_q);
                        end else if (!leaf_ok) begin
                            rsp_paddr <= la_q;
                            rsp_fault <= 1'b1;
                            rsp_cause <= mk_cause(1'b1, wr_q, usr_q);
                        end else begin
                            rsp_paddr <= {fetched.frame, la_q[OFS_W-1:0]};
                            rsp_fault <= 1'b0;
                            rsp_cause <= '0;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import xlate_pkg::*;
#(
    parameter int TLB_ENTRIES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [LA_W-1:0] req_addr,
    input  logic            req_write,
    input  logic            req_user,
    output logic            req_ready,
    input  logic            cfg_wr,
    input  logic [PN_W-1:0] cfg_root_pfn,
    input  logic            cfg_paging,
    output logic            mem_rd_valid,
    output logic [LA_W-1:0] mem_rd_addr,
    input  logic            mem_rsp_valid,
    input  logic [LA_W-1:0] mem_rsp_data,
    output logic            rsp_valid,
    output logic [LA_W-1:0] rsp_paddr,
    output logic            rsp_fault,
    output logic [2:0]      rsp_cause
);

    logic [PN_W-1:0] root_q;
    logic            pg_q;

    // Privileged configuration register
    always_ff @(posedge clk) begin
        if (rst) begin
            root_q <= '0;
            pg_q   <= 1'b0;
        end else if (cfg_wr) begin
            root_q <= cfg_root_pfn;
            pg_q   <= cfg_paging;
        end
    end

    logic            tlb_hit;
    logic [PN_W-1:0] tlb_pfn;
    logic            tlb_wrt;
    logic            tlb_usr;
    logic            fill_en;
    tlb_ent_t        fill_ent;
    fcause_t         cause_s;

    xlate_tlb #(
        .ENTRIES (TLB_ENTRIES)
    ) u_tlb (
        .clk      (clk),
        .rst      (rst),
        .flush    (cfg_wr),
        .lk_vpn   (req_addr[LA_W-1:OFS_W]),
        .lk_hit   (tlb_hit),
        .lk_pfn   (tlb_pfn),
        .lk_wrt   (tlb_wrt),
        .lk_usr   (tlb_usr),
        .fill_en  (fill_en),
        .fill_ent (fill_ent)
    );

    xlate_walk u_walk (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_write     (req_write),
        .req_user      (req_user),
        .req_ready     (req_ready),
        .cfg_busy      (cfg_wr),
        .pg_en         (pg_q),
        .root_pfn      (root_q),
        .tlb_hit       (tlb_hit),
        .tlb_pfn       (tlb_pfn),
        .tlb_wrt       (tlb_wrt),
        .tlb_usr       (tlb_usr),
        .fill_en       (fill_en),
        .fill_ent      (fill_ent),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault),
        .rsp_cause     (cause_s)
    );

    assign rsp_cause = cause_s;

endmodule

// File: rtl/xlate_walker_chk.sv
module xlate_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_addr,
    input logic        cfg_wr,
    input logic        pg_q,
    input logic        tlb_hit,
    input logic        mem_rd_valid,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic        rsp_fault,
    input logic [2:0]  rsp_cause
);

    // R1: idle and quiet in the first cycle after reset
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !rsp_valid && !mem_rd_valid));

    // R2: pass-through answer one cycle after acceptance
    a_r2_bypass_same_addr: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !pg_q) |=>
        (rsp_valid && !rsp_fault && rsp_paddr == $past(req_addr)));

    // R7: a clean response carries a zero cause
    a_r7_clean_cause: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_cause == 3'b000));

    // R8: a hit answers next cycle without touching memory
    a_r8_hit_no_fetch: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && pg_q && tlb_hit) |=> (rsp_valid && !mem_rd_valid));

    // R10: configuration write leaves nothing to hit on
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> !tlb_hit);

    // R11: read requests are single pulses
    a_r11_read_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |=> !mem_rd_valid);

    // R11: no request accepted while a read goes out
    a_r11_busy_reading: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> !req_ready);

endmodule

bind xlate_walker xlate_walker_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .cfg_wr       (cfg_wr),
    .pg_q         (pg_q),
    .tlb_hit      (tlb_hit),
    .mem_rd_valid (mem_rd_valid),
    .rsp_valid    (rsp_valid),
    .rsp_paddr    (rsp_paddr),
    .rsp_fault    (rsp_fault),
    .rsp_cause    (rsp_cause)
);

// File: tb/test_xlate_walker.sv
module test_xlate_walker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        req_ready;
    logic        cfg_wr = 1'b0;
    logic [19:0] cfg_root_pfn = '0;
    logic        cfg_paging = 1'b0;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [2:0]  rsp_cause;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlate_walker i_xlate_walker (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_write     (req_write),
        .req_user      (req_user),
        .req_ready     (req_ready),
        .cfg_wr        (cfg_wr),
        .cfg_root_pfn  (cfg_root_pfn),
        .cfg_paging    (cfg_paging),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault),
        .rsp_cause     (rsp_cause)
    );

    // Physical memory model with fixed read latency
    logic [31:0] pmem [logic [31:0]];
    int          mem_lat = 2;
    int          pend_cnt = 0;
    logic [31:0] pend_addr = '0;
    int          rd_count = 0;
    logic [31:0] rd_log [16];

    always @(negedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (pend_cnt != 0) begin
            if (pend_cnt == 1) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= pmem.exists(pend_addr) ? pmem[pend_addr] : 32'h0;
            end
            pend_cnt <= pend_cnt - 1;
        end
        if (mem_rd_valid) begin
            pend_addr              <= mem_rd_addr;
            pend_cnt               <= mem_lat;
            rd_log[rd_count[3:0]]  <= mem_rd_addr;
            rd_count               <= rd_count + 1;
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] r_pa;
    logic        r_fault;
    logic [2:0]  r_cause;
    int          r_lat;
    int          r_reads;
    int          r_rd0;
    bit          r_busy_ok;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] va(input int di, input int ti, input int off);
        return {di[9:0], ti[9:0], off[11:0]};
    endfunction

    function automatic int miss_lat();
        return 2 * mem_lat + 3;
    endfunction

    task automatic cfg_write(input logic [19:0] root, input logic pg);
        @(negedge clk);
        cfg_wr       = 1'b1;
        cfg_root_pfn = root;
        cfg_paging   = pg;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic xlate(input logic [31:0] la, input logic w, input logic u);
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        r_rd0     = rd_count;
        req_valid = 1'b1;
        req_addr  = la;
        req_write = w;
        req_user  = u;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        r_busy_ok = 1'b1;
        while (!rsp_valid && n < 200) begin
            if (req_ready) r_busy_ok = 1'b0;
            @(negedge clk);
            n++;
        end
        if (!rsp_valid) check("R3", "response timeout", 32'h0, 32'h1);
        r_lat   = n;
        r_pa    = rsp_paddr;
        r_fault = rsp_fault;
        r_cause = rsp_cause;
        r_reads = rd_count - r_rd0;
    endtask

    task automatic expect_ok(input string req, input logic [31:0] la, input logic w,
                             input logic u, input logic [31:0] pa, input int lat, input int reads);
        xlate(la, w, u);
        check(req, "fault", 32'(r_fault), 32'h0);
        check(req, "paddr", r_pa, pa);
        check(req, "latency", 32'(r_lat), 32'(lat));
        check(req, "memory reads", 32'(r_reads), 32'(reads));
        check("R11", "ready low while walking", 32'(r_busy_ok), 32'h1);
    endtask

    task automatic expect_flt(input string req, input logic [31:0] la, input logic w,
                              input logic u, input int cause, input int lat, input int reads);
        xlate(la, w, u);
        check(req, "fault", 32'(r_fault), 32'h1);
        check(req, "cause", 32'(r_cause), 32'(cause));
        check("R7", "fault paddr is linear address", r_pa, la);
        check(req, "latency", 32'(r_lat), 32'(lat));
        check(req, "memory reads", 32'(r_reads), 32'(reads));
        check("R11", "ready low while walking", 32'(r_busy_ok), 32'h1);
    endtask

    // R1, R2
    task automatic t_reset_bypass();
        check("R1", "req_ready after reset", 32'(req_ready), 32'h1);
        check("R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
        check("R1", "mem_rd_valid after reset", 32'(mem_rd_valid), 32'h0);
        expect_ok("R2", 32'hDEAD_BEEF, 1'b1, 1'b1, 32'hDEAD_BEEF, 1, 0);
    endtask

    // R3 at two memory latencies
    task automatic t_walk();
        expect_ok("R3", va(1, 0, 'h123), 1'b0, 1'b0, 32'h0030_0123, miss_lat(), 2);
        check("R3", "directory read address", rd_log[4'(r_rd0)], 32'h0001_0004);
        check("R3", "table read address", rd_log[4'(r_rd0 + 1)], 32'h0002_0000);
        mem_lat = 1;
        expect_ok("R3", va(1, 5, 'hFFF), 1'b0, 1'b0, 32'h0030_5FFF, miss_lat(), 2);
        check("R3", "table read address ti5", rd_log[4'(r_rd0 + 1)], 32'h0002_0014);
        mem_lat = 2;
    endtask

    // R8
    task automatic t_hit();
        expect_ok("R8", va(1, 0, 'h456), 1'b1, 1'b1, 32'h0030_0456, 1, 0);
        expect_ok("R8", va(1, 5, 'h000), 1'b0, 1'b1, 32'h0030_5000, 1, 0);
    endtask

    // R4: cause encodings {user,write,prot}
    task automatic t_not_present();
        expect_flt("R4", va(4, 7, 'h10), 1'b0, 1'b0, 0, mem_lat + 2, 1);
        check("R4", "single directory read", rd_log[4'(r_rd0)], 32'h0001_0010);
        expect_flt("R4", va(1, 3, 'h10), 1'b1, 1'b1, 6, miss_lat(), 2);
        expect_flt("R4", va(1, 3, 'h14), 1'b1, 1'b1, 6, miss_lat(), 2);
        expect_ok("R4", va(1, 4, 'h001), 1'b0, 1'b0, 32'h0030_4001, miss_lat(), 2);
    endtask

    // R5
    task automatic t_write_prot();
        expect_flt("R5", va(1, 1, 'h20), 1'b1, 1'b1, 7, miss_lat(), 2);
        expect_ok("R5", va(1, 1, 'h24), 1'b0, 1'b1, 32'h0030_1024, 1, 0);
        expect_flt("R5", va(1, 1, 'h28), 1'b1, 1'b0, 3, 1, 0);
        expect_flt("R5", va(3, 0, 'h00), 1'b1, 1'b0, 3, miss_lat(), 2);
    endtask

    // R6
    task automatic t_user_prot();
        expect_flt("R6", va(2, 0, 'h40), 1'b0, 1'b1, 5, miss_lat(), 2);
        expect_ok("R6", va(2, 0, 'h44), 1'b1, 1'b0, 32'h0040_0044, 1, 0);
        expect_flt("R6", va(2, 0, 'h48), 1'b0, 1'b1, 5, 1, 0);
        expect_flt("R6", va(1, 2, 'h00), 1'b0, 1'b1, 5, miss_lat(), 2);
    endtask

    // R9
    task automatic t_round_robin();
        cfg_write(20'h00010, 1'b1);
        for (int k = 4; k < 8; k++) begin
            expect_ok("R9", va(1, k, 'h0), 1'b0, 1'b0, {20'h00300 + 20'(k), 12'h000}, miss_lat(), 2);
        end
        expect_ok("R9", va(1, 0, 'h8), 1'b0, 1'b0, 32'h0030_0008, miss_lat(), 2);
        expect_ok("R9", va(1, 5, 'h8), 1'b0, 1'b0, 32'h0030_5008, 1, 0);
        expect_ok("R9", va(1, 4, 'h8), 1'b0, 1'b0, 32'h0030_4008, miss_lat(), 2);
        expect_ok("R9", va(1, 6, 'h8), 1'b0, 1'b0, 32'h0030_6008, 1, 0);
    endtask

    // R10
    task automatic t_flush();
        expect_ok("R10", va(1, 7, 'h10), 1'b0, 1'b0, 32'h0030_7010, 1, 0);
        cfg_write(20'h00010, 1'b1);
        expect_ok("R10", va(1, 7, 'h10), 1'b0, 1'b0, 32'h0030_7010, miss_lat(), 2);
        cfg_write(20'h00011, 1'b1);
        expect_ok("R10", va(1, 0, 'h8), 1'b0, 1'b0, 32'h0040_0008, miss_lat(), 2);
        check("R10", "new root directory read", rd_log[4'(r_rd0)], 32'h0001_1004);
        cfg_write(20'h00011, 1'b0);
        expect_ok("R10", va(5, 9, 'hABC), 1'b1, 1'b1, va(5, 9, 'hABC), 1, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        pmem[32'h0001_0004] = 32'h0002_0007;
        pmem[32'h0001_0008] = 32'h0002_1003;
        pmem[32'h0001_000C] = 32'h0002_2005;
        pmem[32'h0001_1004] = 32'h0002_1007;
        for (int k = 0; k < 8; k++) begin
            if (k == 1)      pmem[32'h0002_0000 + 32'(k * 4)] = 32'h0030_1005;
            else if (k == 2) pmem[32'h0002_0000 + 32'(k * 4)] = 32'h0030_2003;
            else if (k == 4) pmem[32'h0002_0000 + 32'(k * 4)] = 32'h0030_4FF7;
            else if (k != 3) pmem[32'h0002_0000 + 32'(k * 4)] = {20'h00300 + 20'(k), 12'h007};
        end
        pmem[32'h0002_1000] = 32'h0040_0007;
        pmem[32'h0002_2000] = 32'h0050_0007;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_bypass();
        cfg_write(20'h00010, 1'b1);
        t_walk();
        t_hit();
        t_not_present();
        t_write_prot();
        t_user_prot();
        t_round_robin();
        t_flush();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

endmodule